// File: doc/BRIEF.md
# GPIO interrupt line router

The router takes the interrupt lines of three GPIO controllers (14, 24 and 32 lines) and places them on 41 interrupt-controller inputs. Of these, 38 are exclusive slots, each carrying one GPIO line, and 3 are shared lines, one per controller. A 32-bit configuration register decides which of two competing lines owns each contested exclusive slot. The line that loses is not dropped. It is ORed into its own controller's shared output.

Slots 0 to 13 are contested between controller 0 and controller 2. Slots 14 to 31 are contested between the first 18 lines of controller 1 and the upper lines of controller 2. The last six lines of controller 1 always own slots 32 to 37. The routing is combinational from the GPIO lines and the registered configuration. Firmware writes the register once and reads it back through a plain write strobe with a data word.

The router has no masking, edge detection or acknowledgement. Those functions belong to the GPIO controllers and to the interrupt controller that follows.

Top module: `gpio_irq_router`

## Requirements
- R1: While reset is low, and after it is released with no write, the configuration reads back 0x00000000 and routing follows an all-zero configuration.
- R2: When `wr_en_i` is high at a rising clock edge, `rd_data_o` shows `wr_data_i` from that edge onward. When `wr_en_i` is low at an edge, the register keeps its value even if `wr_data_i` changes.
- R3: For slot s in 0..13, `irq_o[s]` equals `gpio2_irq_i[s]` when config bit s is 1, and `gpio0_irq_i[s]` when it is 0.
- R4: For slot s in 14..31, `irq_o[s]` equals `gpio2_irq_i[s]` when config bit s is 1, and `gpio1_irq_i[s-14]` when it is 0.
- R5: `irq_o[32+k]` equals `gpio1_irq_i[18+k]` for k in 0..5, whatever the configuration holds.
- R6: `irq_o[38]` is the OR of every `gpio0_irq_i[i]` whose config bit i is 1.
- R7: `irq_o[39]` is the OR of every `gpio1_irq_i[j]`, j in 0..17, whose config bit j+14 is 1.
- R8: `irq_o[40]` is the OR of every `gpio2_irq_i[i]` whose config bit i is 0.
- R9: No input is suppressed. Each asserted input drives exactly one output, so a single asserted input raises exactly one bit of `irq_o`. Any asserted input makes `irq_o` non-zero.
- R10: A change on a GPIO input reaches `irq_o` within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_data_i | input | 32 | Configuration write data |
| rd_data_o | output | 32 | Configuration readback |
| gpio0_irq_i | input | 14 | Controller 0 interrupt lines |
| gpio1_irq_i | input | 24 | Controller 1 interrupt lines |
| gpio2_irq_i | input | 32 | Controller 2 interrupt lines |
| irq_o | output | 41 | Slots 0..37 exclusive, 38..40 shared for controllers 0, 1, 2 |

## Verification
The bench builds the router with its default widths of 14, 24 and 32 lines. This brings the following within reach:
- both contested ranges, including the boundary slots 13 and 14;
- the six-line fixed tail of controller 1;
- every bit of the 32-bit register.

Fixed configurations (all zeros, all ones, alternating, one boundary-only value) and a few hundred random configurations are each paired with dense, sparse and random input words. A walking-one pass then raises each of the 70 inputs alone and checks that it lands on exactly one output.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned DEF_G0_LINES = 14;
  localparam int unsigned DEF_G1_LINES = 24;
  localparam int unsigned DEF_G2_LINES = 32;
  localparam int unsigned N_SHARED     = 3;

  typedef enum logic [1:0] {
    SH_G0 = 2'd0,
    SH_G1 = 2'd1,
    SH_G2 = 2'd2
  } shared_idx_e;
endpackage

// File: rtl/irq_cfg_reg.sv
module irq_cfg_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cfg_o <= '0;
    else if (wr_en_i) cfg_o <= wr_data_i;
  end
endmodule

// File: rtl/irq_route_slot.sv
// One contested slot: sel=1 gives the slot to the high (controller 2) line.
module irq_route_slot (
  input  logic sel_i,
  input  logic low_i,
  input  logic high_i,
  output logic direct_o,
  output logic low_shared_o,
  output logic high_shared_o
);
  always_comb begin
    direct_o      = sel_i ? high_i : low_i;
    low_shared_o  = sel_i & low_i;
    high_shared_o = ~sel_i & high_i;
  end
endmodule

// File: rtl/irq_or_reduce.sv
module irq_or_reduce #(
  parameter int unsigned W = 14
) (
  input  logic [W-1:0] lines_i,
  output logic         any_o
);
  assign any_o = |lines_i;
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_G0 = DEF_G0_LINES,
  parameter int unsigned N_G1 = DEF_G1_LINES,
  parameter int unsigned N_G2 = DEF_G2_LINES,
  localparam int unsigned N_MIX1   = N_G2 - N_G0,
  localparam int unsigned N_FIX    = N_G1 - N_MIX1,
  localparam int unsigned N_DIRECT = N_G2 + N_FIX,
  localparam int unsigned N_OUT    = N_DIRECT + N_SHARED
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [N_G2-1:0]   wr_data_i,
  output logic [N_G2-1:0]   rd_data_o,
  input  logic [N_G0-1:0]   gpio0_irq_i,
  input  logic [N_G1-1:0]   gpio1_irq_i,
  input  logic [N_G2-1:0]   gpio2_irq_i,
  output logic [N_OUT-1:0]  irq_o
);
  logic [N_G2-1:0]     cfg_q;
  logic [N_DIRECT-1:0] direct;
  logic [N_G2-1:0]     low_lose;
  logic [N_G2-1:0]     g2_lose;
  logic [N_SHARED-1:0] shared;

  irq_cfg_reg #(.W(N_G2)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .cfg_o     (cfg_q)
  );

  assign rd_data_o = cfg_q;

  for (genvar s = 0; s < N_G2; s++) begin : g_slot
    logic low_line;
    if (s < N_G0) begin : g_lo0
      assign low_line = gpio0_irq_i[s];
    end else begin : g_lo1
      assign low_line = gpio1_irq_i[s-N_G0];
    end
    irq_route_slot u_slot (
      .sel_i         (cfg_q[s]),
      .low_i         (low_line),
      .high_i        (gpio2_irq_i[s]),
      .direct_o      (direct[s]),
      .low_shared_o  (low_lose[s]),
      .high_shared_o (g2_lose[s])
    );
  end

  // Controller 1 tail lines own the slots above the contested range.
  for (genvar k = 0; k < N_FIX; k++) begin : g_fix
    assign direct[N_G2+k] = gpio1_irq_i[N_MIX1+k];
  end

  irq_or_reduce #(.W(N_G0)) u_or0 (
    .lines_i (low_lose[N_G0-1:0]),
    .any_o   (shared[SH_G0])
  );
  irq_or_reduce #(.W(N_MIX1)) u_or1 (
    .lines_i (low_lose[N_G2-1:N_G0]),
    .any_o   (shared[SH_G1])
  );
  irq_or_reduce #(.W(N_G2)) u_or2 (
    .lines_i (g2_lose),
    .any_o   (shared[SH_G2])
  );

  assign irq_o = {shared, direct};

  // R2
  p_wr_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o == $past(wr_data_i));
  // R2
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rd_data_o));
  // R9
  p_no_loss_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|{gpio0_irq_i, gpio1_irq_i, gpio2_irq_i}) == (|irq_o));
  // R6
  p_sh0_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[N_G0-1:0] == '0) |-> !irq_o[N_DIRECT]);
  // R8
  p_sh2_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&rd_data_o) |-> !irq_o[N_OUT-1]);
endmodule

// File: tb/sim_gpio_irq_router.sv
module sim_gpio_irq_router;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] cfg;
    logic [13:0] g0;
    logic [23:0] g1;
    logic [31:0] g2;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0000, 14'h3fff, 24'hff_ffff, 32'hffff_ffff},
    '{32'hffff_ffff, 14'h3fff, 24'hff_ffff, 32'hffff_ffff},
    '{32'h0000_0000, 14'h0000, 24'h00_0000, 32'h0000_0001},
    '{32'hffff_ffff, 14'h0001, 24'h00_0000, 32'h0000_0000},
    '{32'haaaa_5555, 14'h1555, 24'h2a_aaaa, 32'h5555_aaaa},
    '{32'h5555_aaaa, 14'h2aaa, 24'h15_5555, 32'haaaa_5555},
    '{32'h0000_6000, 14'h2000, 24'h00_0001, 32'h0000_4000},
    '{32'hffff_9fff, 14'h2000, 24'hfc_0001, 32'h0000_6000}
  };

  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [13:0] g0 = '0;
  logic [23:0] g1 = '0;
  logic [31:0] g2 = '0;
  logic [40:0] irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_router u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .gpio0_irq_i(g0), .gpio1_irq_i(g1),
    .gpio2_irq_i(g2), .irq_o(irq)
  );

  function automatic logic [40:0] ref_route(logic [31:0] c, logic [13:0] a,
                                            logic [23:0] b, logic [31:0] d);
    logic [40:0] r = '0;
    for (int i = 0; i < 14; i++) begin
      r[i]  = c[i] ? d[i] : a[i];
      r[38] = r[38] | (a[i] & c[i]);
    end
    for (int i = 14; i < 32; i++) begin
      r[i]  = c[i] ? d[i] : b[i-14];
      r[39] = r[39] | (b[i-14] & c[i]);
    end
    for (int i = 0; i < 32; i++) r[40] = r[40] | (d[i] & ~c[i]);
    for (int k = 0; k < 6; k++) r[32+k] = b[18+k];
    return r;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_route(logic [31:0] c);
    logic [40:0] e = ref_route(c, g0, g1, g2);
    chk("R3 ctrl0 slots", 64'(irq[13:0]),  64'(e[13:0]));
    chk("R4 ctrl1 slots", 64'(irq[31:14]), 64'(e[31:14]));
    chk("R5 fixed slots", 64'(irq[37:32]), 64'(e[37:32]));
    chk("R6 shared0",     64'(irq[38]),    64'(e[38]));
    chk("R7 shared1",     64'(irq[39]),    64'(e[39]));
    chk("R8 shared2",     64'(irq[40]),    64'(e[40]));
    chk("R9 no loss", 64'(|irq), 64'(|{g0, g1, g2}));
  endtask

  task automatic apply(logic [31:0] c, logic [13:0] a, logic [23:0] b, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_data = c;
    @(negedge clk);
    wr_en = 0; wr_data = ~c;
    g0 = a; g1 = b; g2 = d;
    #1;
    chk("R2 readback", 64'(rd_data), 64'(c));
    chk_route(c);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    g0 = 14'h0155; g1 = 24'h00_0aaa; g2 = 32'h0000_f0f0;
    #(CLK_PERIOD * 2 + 1);
    chk("R1 reset readback", 64'(rd_data), 64'h0);
    chk_route(32'h0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", 64'(rd_data), 64'h0);
    chk_route(32'h0);

    for (int v = 0; v < NV; v++) apply(VECS[v].cfg, VECS[v].g0, VECS[v].g1, VECS[v].g2);

    // R2: a held strobe-free cycle with changing data keeps the register.
    apply(32'h1234_5678, 14'h0, 24'h0, 32'h0);
    @(negedge clk);
    wr_data = 32'hdead_beef;
    @(negedge clk);
    chk("R2 hold without strobe", 64'(rd_data), 64'h1234_5678);

    // R10: input change seen without a clock edge.
    @(negedge clk);
    g1 = 24'h80_0000;
    #1;
    chk("R10 same-cycle fixed", 64'(irq[37]), 64'h1);
    g1 = 24'h0; g2 = 32'h0000_0001;
    #1;
    chk("R10 same-cycle shared2", 64'(irq[40]), 64'h1);

    // R9: each input alone lands on exactly one output.
    for (int n = 0; n < 70; n++) begin
      logic [31:0] rc = $urandom;
      logic [69:0] one = 70'(1) << n;
      apply(rc, one[13:0], one[37:14], one[69:38]);
      chk("R9 single input one output", 64'($countones(irq)), 64'h1);
    end

    for (int t = 0; t < 300; t++) begin
      logic [31:0] rc = $urandom;
      logic [31:0] ra = $urandom;
      logic [31:0] rb = $urandom;
      logic [31:0] rd = $urandom;
      apply(rc, ra[13:0], rb[23:0], rd);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule